// File: doc/BRIEF.md
# Pipeline Hazard Control Unit

This block decides, every cycle, which pipeline registers of a five-stage in-order pipeline must hold their contents and which must be replaced by a no-op. The stages are fetch, decode, execute, memory and write-back. It looks at the operation, source and destination register numbers, branch outcome and status code of the instructions currently held in each stage. From these it produces one stall bit and one bubble bit per pipeline register.

It resolves four kinds of trouble:

- an operand that is still being loaded,
- return instructions, whose target is unknown until write-back,
- branches that the always-taken guess got wrong,
- instructions that raised an exception.

It also resolves the combinations of these that can occur together.

A compact model of the four instruction-carrying pipeline registers and of the fetch counter is included, so the effect of the control can be observed at the ports. The datapath and the forwarding paths are not part of the block.

Each instruction word is 17 bits wide, packed most significant first, with these fields:

| Bits | Field |
|------|-------|
| [16:14] | operation |
| [13:10] | first source register |
| [9:6] | second source register |
| [5:2] | destination register |
| [1:0] | status |

Operation codes are: 0 no-op, 1 ALU, 2 load, 3 store, 4 conditional jump, 5 return, 6 halt, 7 other.

Status codes are: 0 normal, 1 halt, 2 bad address, 3 bad instruction. Any nonzero status is an exception.

Register number 15 means "no register". The no-op word has operation 0, all three register fields equal to 15, and status 0.

Stall and bubble vectors use bit 0 for F, bit 1 for D, bit 2 for E, bit 3 for M and bit 4 for W.

Top module: `pipe_ctl_top`

## Requirements
- R1: While reset is active, D, E, M and W hold the no-op word, the fetch counter is 0, and all stall and bubble bits are 0.
- R2: When E holds a load whose destination equals a source of the instruction in D, F and D stall and E receives a bubble.
- R3: A register number of 15 never produces a match in the load/use comparison.
- R4: A return in D, E or M stalls F and bubbles D, unless R8 applies.
- R5: A conditional jump in E with the condition input low is a misprediction: D and E receive bubbles and F is not stalled for it.
- R6: When a misprediction coincides with a return in D, F stalls and both D and E are bubbled, which cancels the return.
- R7: A bubbled register takes the no-op word on the next edge, dropping any exception status. A stalled register keeps its word. Otherwise a register takes its predecessor's word and the fetch counter increments.
- R8: When a load/use hazard coincides with a return in D, F and D stall, E is bubbled, and D is not bubbled.
- R9: A load or store in M with status 0 and the memory error input high carries status 2 into W.
- R10: When the status leaving M (after R9) or the status in W is nonzero, M is bubbled. In that case condition-code writes (ALU in E) and memory writes (store in M) are disabled. Otherwise they are enabled for those operations.
- R11: A nonzero status in W stalls W, raises the halted output, and is the reported status. Because instructions stay in order, this is always the oldest exception.
- R12: No register ever has its stall and bubble bits set together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| f_instr | input | 17 | Instruction word produced by fetch this cycle |
| e_cnd | input | 1 | Branch condition computed for the instruction in E |
| mem_err | input | 1 | Address error from the data memory for the instruction in M |
| stall | output | 5 | Per-register hold request (F, D, E, M, W) |
| bubble | output | 5 | Per-register no-op injection request |
| f_pc | output | 8 | Fetch counter held in F |
| d_instr | output | 17 | Word held in D |
| e_instr | output | 17 | Word held in E |
| m_instr | output | 17 | Word held in M |
| w_instr | output | 17 | Word held in W |
| cc_wr_en | output | 1 | Condition-code update enable for the ALU operation in E |
| mem_wr_en | output | 1 | Data-memory write enable for the store in M |
| halted | output | 1 | An exception has reached W |
| rep_stat | output | 2 | Status reported from W |

## Verification
The assertions assume that an instruction occupies exactly one stage, so a load and a mispredicted jump are never in E together. They also assume that the branch condition and memory error inputs are meaningful only for the instruction currently in E or M. The stimulus respects both assumptions, because every word enters through the fetch input and moves through the pipeline registers. The only values supplied directly are the condition and error bits, and these are drawn fresh each cycle. Register numbers are drawn from a small set that includes 15, so load/use matches, no-register cases and their overlap with returns and mispredictions recur often over several reset episodes.

// File: rtl/pipe_ctl_pkg.sv
package pipe_ctl_pkg;
    localparam int REG_W  = 4;
    localparam int OP_W   = 3;
    localparam int NSTG   = 5;
    localparam int STG_F  = 0;
    localparam int STG_D  = 1;
    localparam int STG_E  = 2;
    localparam int STG_M  = 3;
    localparam int STG_W  = 4;

    typedef enum logic [OP_W-1:0] {
        OP_NOP   = 3'd0,
        OP_ALU   = 3'd1,
        OP_LOAD  = 3'd2,
        OP_STORE = 3'd3,
        OP_JCC   = 3'd4,
        OP_RET   = 3'd5,
        OP_HALT  = 3'd6,
        OP_MISC  = 3'd7
    } op_t;

    typedef enum logic [1:0] {
        ST_OK  = 2'd0,
        ST_HLT = 2'd1,
        ST_ADR = 2'd2,
        ST_INS = 2'd3
    } stat_t;

    localparam logic [REG_W-1:0] REG_NONE = '1;

    typedef struct packed {
        op_t              op;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic [REG_W-1:0] dst;
        stat_t            stat;
    } instr_t;

    localparam int INSTR_W = $bits(instr_t);
    localparam instr_t NOP_INSTR = '{op: OP_NOP, src_a: REG_NONE, src_b: REG_NONE,
                                     dst: REG_NONE, stat: ST_OK};
endpackage

// File: rtl/pipe_reg.sv
module pipe_reg #(
    parameter int           W   = 8,
    parameter logic [W-1:0] BUB = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stall,
    input  logic         bubble,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    always_comb begin
        q_d = din;
        if (stall)       q_d = q_q;
        else if (bubble) q_d = BUB;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= BUB;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/hazard_ctl.sv
module hazard_ctl
    import pipe_ctl_pkg::*;
(
    input  op_t              d_op,
    input  logic [REG_W-1:0] d_src_a,
    input  logic [REG_W-1:0] d_src_b,
    input  op_t              e_op,
    input  logic [REG_W-1:0] e_dst,
    input  logic             e_cnd,
    input  op_t              m_op,
    input  stat_t            m_stat_q,
    input  logic             mem_err,
    input  stat_t            w_stat_q,
    output logic [NSTG-1:0]  stall,
    output logic [NSTG-1:0]  bubble,
    output stat_t            m_stat,
    output logic             cc_wr_en,
    output logic             mem_wr_en
);
    logic load_use, ret_pend, mispred, m_exc, w_exc, m_mem;

    always_comb begin
        load_use = (e_op == OP_LOAD) && (e_dst != REG_NONE) &&
                   ((e_dst == d_src_a) || (e_dst == d_src_b));
        ret_pend = (d_op == OP_RET) || (e_op == OP_RET) || (m_op == OP_RET);
        mispred  = (e_op == OP_JCC) && !e_cnd;
        m_mem    = (m_op == OP_LOAD) || (m_op == OP_STORE);
        m_stat   = (m_stat_q == ST_OK && m_mem && mem_err) ? ST_ADR : m_stat_q;
        m_exc    = (m_stat != ST_OK);
        w_exc    = (w_stat_q != ST_OK);

        stall  = '0;
        bubble = '0;
        stall[STG_F]  = load_use || ret_pend;
        stall[STG_D]  = load_use;
        bubble[STG_D] = mispred || (ret_pend && !load_use);
        bubble[STG_E] = mispred || load_use;
        bubble[STG_M] = m_exc || w_exc;
        stall[STG_W]  = w_exc;

        cc_wr_en  = (e_op == OP_ALU)   && !m_exc && !w_exc;
        mem_wr_en = (m_op == OP_STORE) && !m_exc && !w_exc;
    end
endmodule

// File: rtl/pipe_ctl_top.sv
module pipe_ctl_top
    import pipe_ctl_pkg::*;
#(
    parameter int PC_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INSTR_W-1:0] f_instr,
    input  logic               e_cnd,
    input  logic               mem_err,
    output logic [NSTG-1:0]    stall,
    output logic [NSTG-1:0]    bubble,
    output logic [PC_W-1:0]    f_pc,
    output logic [INSTR_W-1:0] d_instr,
    output logic [INSTR_W-1:0] e_instr,
    output logic [INSTR_W-1:0] m_instr,
    output logic [INSTR_W-1:0] w_instr,
    output logic               cc_wr_en,
    output logic               mem_wr_en,
    output logic               halted,
    output logic [1:0]         rep_stat
);
    logic [NSTG-1:1][INSTR_W-1:0] stg_in;
    logic [NSTG-1:1][INSTR_W-1:0] stg_q;
    instr_t d_w, e_w, m_w, w_w, w_in;
    stat_t  m_stat;
    logic [PC_W-1:0] f_pc_d, f_pc_q;

    assign d_w = instr_t'(stg_q[STG_D]);
    assign e_w = instr_t'(stg_q[STG_E]);
    assign m_w = instr_t'(stg_q[STG_M]);
    assign w_w = instr_t'(stg_q[STG_W]);

    hazard_ctl u_ctl (
        .d_op      (d_w.op),
        .d_src_a   (d_w.src_a),
        .d_src_b   (d_w.src_b),
        .e_op      (e_w.op),
        .e_dst     (e_w.dst),
        .e_cnd     (e_cnd),
        .m_op      (m_w.op),
        .m_stat_q  (m_w.stat),
        .mem_err   (mem_err),
        .w_stat_q  (w_w.stat),
        .stall     (stall),
        .bubble    (bubble),
        .m_stat    (m_stat),
        .cc_wr_en  (cc_wr_en),
        .mem_wr_en (mem_wr_en)
    );

    always_comb begin
        w_in         = m_w;
        w_in.stat    = m_stat;
        stg_in[STG_D] = f_instr;
        stg_in[STG_E] = stg_q[STG_D];
        stg_in[STG_M] = stg_q[STG_E];
        stg_in[STG_W] = w_in;
    end

    for (genvar i = 1; i < NSTG; i++) begin : g_stage
        pipe_reg #(.W(INSTR_W), .BUB(NOP_INSTR)) u_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .stall  (stall[i]),
            .bubble (bubble[i]),
            .din    (stg_in[i]),
            .q      (stg_q[i])
        );
    end

    always_comb begin
        f_pc_d = stall[STG_F] ? f_pc_q : f_pc_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_pc_q <= '0;
        else        f_pc_q <= f_pc_d;
    end

    assign f_pc     = f_pc_q;
    assign d_instr  = stg_q[STG_D];
    assign e_instr  = stg_q[STG_E];
    assign m_instr  = stg_q[STG_M];
    assign w_instr  = stg_q[STG_W];
    assign halted   = (w_w.stat != ST_OK);
    assign rep_stat = w_w.stat;

    AST_STALL_BUBBLE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (stall & bubble) == '0); // R12
    AST_D_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall[STG_D] |=> d_instr == $past(d_instr)); // R2
    AST_NONE_NOMATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (e_w.dst == REG_NONE) |-> !stall[STG_D]); // R3
    AST_F_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        stall[STG_F] |=> $stable(f_pc)); // R4
    AST_E_BUBBLE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        bubble[STG_E] |=> e_instr == NOP_INSTR); // R7
    AST_NO_WR_BEHIND_EXC: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !cc_wr_en && !mem_wr_en); // R10
    AST_W_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(w_instr) && halted); // R11
endmodule

// File: tb/pipe_ctl_top_bench.sv
module pipe_ctl_top_bench;
    import pipe_ctl_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [INSTR_W-1:0] f_instr;
    logic e_cnd, mem_err;
    logic [NSTG-1:0] stall, bubble;
    logic [7:0] f_pc;
    logic [INSTR_W-1:0] d_instr, e_instr, m_instr, w_instr;
    logic cc_wr_en, mem_wr_en, halted;
    logic [1:0] rep_stat;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    pipe_ctl_top u_pipe_ctl_top (
        .clk(clk), .rst_n(rst_n), .f_instr(f_instr), .e_cnd(e_cnd), .mem_err(mem_err),
        .stall(stall), .bubble(bubble), .f_pc(f_pc), .d_instr(d_instr), .e_instr(e_instr),
        .m_instr(m_instr), .w_instr(w_instr), .cc_wr_en(cc_wr_en), .mem_wr_en(mem_wr_en),
        .halted(halted), .rep_stat(rep_stat)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [REG_W-1:0] pick_reg();
        int r = $urandom % 5;
        return (r == 4) ? REG_NONE : REG_W'(r);
    endfunction

    function automatic instr_t pick_instr();
        instr_t x;
        int r = $urandom % 16;
        case (r)
            0, 1, 2, 3: x.op = OP_ALU;
            4, 5, 6:    x.op = OP_LOAD;
            7:          x.op = OP_STORE;
            8, 9:       x.op = OP_JCC;
            10:         x.op = OP_RET;
            11:         x.op = OP_HALT;
            12:         x.op = OP_MISC;
            default:    x.op = OP_NOP;
        endcase
        x.src_a = pick_reg();
        x.src_b = pick_reg();
        x.dst   = pick_reg();
        x.stat  = ($urandom % 28 == 0) ? stat_t'(1 + $urandom % 3) : ST_OK;
        return x;
    endfunction

    instr_t ds, es, ms, ws;
    logic [7:0] pcs;

    task automatic step_check();
        logic lu, rp, mis, dret, mmem, mexc, wexc;
        logic [NSTG-1:0] xs, xb;
        stat_t mst;
        instr_t wn;
        string tg;
        lu   = es.op == OP_LOAD && es.dst != REG_NONE && (es.dst == ds.src_a || es.dst == ds.src_b);
        dret = ds.op == OP_RET;
        rp   = dret || es.op == OP_RET || ms.op == OP_RET;
        mis  = es.op == OP_JCC && !e_cnd;
        mmem = ms.op == OP_LOAD || ms.op == OP_STORE;
        mst  = (ms.stat == ST_OK && mmem && mem_err) ? ST_ADR : ms.stat;
        mexc = mst != ST_OK;
        wexc = ws.stat != ST_OK;
        xs = '0; xb = '0;
        xs[0] = lu || rp;   xs[1] = lu;
        xb[1] = mis || (rp && !lu);  xb[2] = mis || lu;
        xb[3] = mexc || wexc;        xs[4] = wexc;
        if (lu && dret)                             tg = "R8";
        else if (mis && dret)                       tg = "R6";
        else if (lu)                                tg = "R2";
        else if (mis)                               tg = "R5";
        else if (rp)                                tg = "R4";
        else if (es.op == OP_LOAD && es.dst == REG_NONE) tg = "R3";
        else                                        tg = "R13_none";
        chk({tg, " stall FDE"},  32'(stall[2:0]),  32'(xs[2:0]));
        chk({tg, " bubble FDE"}, 32'(bubble[2:0]), 32'(xb[2:0]));
        chk("R10 bubble M", 32'(bubble[3]), 32'(xb[3]));
        chk("R11 stall W", 32'(stall[4]), 32'(xs[4]));
        chk("R12 no overlap", 32'(stall & bubble), 32'd0);
        chk("R10 cc write", 32'(cc_wr_en), 32'(es.op == OP_ALU && !mexc && !wexc));
        chk("R10 mem write", 32'(mem_wr_en), 32'(ms.op == OP_STORE && !mexc && !wexc));
        chk("R11 halted", 32'(halted), 32'(wexc));
        chk("R11 reported status", 32'(rep_stat), 32'(ws.stat));
        wn = ms; wn.stat = mst;
        if (!xs[0]) pcs = pcs + 8'd1;
        ws = xs[4] ? ws : wn;
        ms = xb[3] ? NOP_INSTR : es;
        es = xb[2] ? NOP_INSTR : ds;
        ds = xs[1] ? ds : (xb[1] ? NOP_INSTR : instr_t'(f_instr));
    endtask

    task automatic state_check();
        chk("R7 fetch counter", 32'(f_pc), 32'(pcs));
        chk("R7 D word", 32'(d_instr), 32'(ds));
        chk("R7 E word", 32'(e_instr), 32'(es));
        chk("R7 M word", 32'(m_instr), 32'(ms));
        chk("R9 W word", 32'(w_instr), 32'(ws));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        f_instr = NOP_INSTR; e_cnd = 1'b0; mem_err = 1'b0;
        for (int ep = 0; ep < 8; ep++) begin
            rst_n = 1'b0;
            f_instr = pick_instr();
            repeat (2) @(negedge clk);
            #1;
            chk("R1 reset D", 32'(d_instr), 32'(NOP_INSTR));
            chk("R1 reset W", 32'(w_instr), 32'(NOP_INSTR));
            chk("R1 reset pc", 32'(f_pc), 32'd0);
            chk("R1 reset stall", 32'(stall), 32'd0);
            chk("R1 reset bubble", 32'(bubble), 32'd0);
            ds = NOP_INSTR; es = NOP_INSTR; ms = NOP_INSTR; ws = NOP_INSTR; pcs = '0;
            for (int c = 0; c < 500; c++) begin
                @(negedge clk);
                rst_n   = 1'b1;
                f_instr = pick_instr();
                e_cnd   = 1'($urandom % 2);
                mem_err = ($urandom % 10 == 0);
                #1;
                state_check();
                step_check();
            end
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule